// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models the target side of a 128-byte serial EEPROM that sits on a two-wire bus (clock line plus bidirectional data line). The bus lines are brought into the system clock domain through synchronizers. The block recognises bus start and stop conditions, shifts bytes in and out one bit per clock pulse, and acknowledges accepted bytes by pulling the data line low through an open-drain enable.

A write consists of a control byte, a word address and any number of data bytes. The data bytes are gathered in a page-sized buffer. If more bytes arrive than the buffer holds, the oldest are dropped. A stop condition commits the buffered bytes into the array during a timed programming interval. While that interval runs, the target stays silent on the bus. A read returns bytes from an internal pointer, one after another, until the controller declines to acknowledge.

The block is placed on a bus with external pull-ups. The bus data line is the wired-AND of the controller's drive and the inverse of `sda_pull`.

Top module: `seeprom_target`

## Requirements
- R1: While and after reset, `sda_pull` is 0 (data line released).
- R2: A control byte whose upper nibble is not 4'b1010 is not acknowledged. All later bytes up to the next start condition are ignored and are not acknowledged.
- R3: A control byte with upper nibble 4'b1010 is acknowledged. Its bit 0 selects the direction, with 1 meaning read. In a write, the word address byte and each data byte are acknowledged. After the stop condition and the programming interval, the data reads back from that address.
- R4: When a write carries more data bytes than the page size (16), only the last 16 are kept. They are stored at consecutive addresses from the word address, the oldest kept byte first.
- R5: Stored addresses wrap inside the 16-byte-aligned page of the word address. Locations outside that page are not changed.
- R6: During the programming interval, no byte is acknowledged, including the control byte.
- R7: The programming interval begins only on a stop condition ending a write that holds at least one data byte. It lasts PROG_CYCLES system clocks, after which control bytes are acknowledged again.
- R8: A sequential read returns successive addresses and wraps from 0x7F to 0x00.
- R9: After the controller withholds its acknowledge on a read byte, the target keeps the data line released until the next start condition.
- R10: A write holding only the word address sets the read pointer and starts no programming interval.
- R11: Bit 7 of the word address byte is ignored.
- R12: `sda_pull` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume that the controller follows the bus protocol. It changes the data line only while the clock line is low, apart from deliberate start and stop conditions. It never raises a start or stop while the target is pulling the data line low. Each bus phase is held for several system clocks, so the synchronized view of the lines stays in order. The bench controller holds each quarter of a bit period for eight system clocks and changes the data line only in the middle of a clock-low phase. It issues start and stop only after the target has released the line.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } bus_st_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/seeprom_wbuf.sv
module seeprom_wbuf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] rd_off,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [IW:0]   DEPTHW = (IW + 1)'(DEPTH);
  localparam logic [IW-1:0] LASTI  = IW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wp;
  logic [IW-1:0] oldest;
  logic [IW:0]   sum;
  logic [IW-1:0] ridx;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      count <= '0;
    end else if (push) begin
      wp    <= (wp == LASTI) ? '0 : wp + 1'b1;
      count <= (count == FULL) ? count : count + 1'b1;
    end
  end

  always_comb begin
    oldest = (count == FULL) ? wp : '0;
    sum    = {1'b0, oldest} + {1'b0, rd_off};
    ridx   = (sum >= DEPTHW) ? IW'(sum - DEPTHW) : sum[IW-1:0];
    dout   = mem[ridx];
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL) else $error("buffer fill exceeds depth"); // R4
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
  import seeprom_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 128,
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned PROG_CYCLES = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);
  localparam int unsigned AW = $clog2(MEM_BYTES);
  localparam int unsigned PW = $clog2(PAGE_BYTES);
  localparam int unsigned CW = $clog2(PAGE_BYTES + 1);
  localparam int unsigned TW = $clog2(PROG_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  seeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_e           st;
  logic [3:0]        cnt;
  logic              ack_ph;
  logic              got_ack;
  logic              rd_req;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txq;
  logic [AW-1:0]     ptr;
  logic [AW-1:0]     base;
  logic [TW-1:0]     timer;
  logic [CW-1:0]     cidx;
  logic              busy;

  logic              byte_done;
  logic              buf_clr, buf_push;
  logic [BYTE_W-1:0] buf_dout;
  logic [CW-1:0]     buf_count;
  logic              commit_go;
  logic              prog_go;
  logic [PW-1:0]     low_off;
  logic [AW-1:0]     mem_waddr;
  logic [BYTE_W-1:0] mem_rdata;

  assign busy      = (timer != '0);
  assign byte_done = scl_fall && !ack_ph && (cnt == 4'd8);
  assign buf_clr   = (st == ST_ADDR) && byte_done && !start_det && !stop_det;
  assign buf_push  = (st == ST_WDATA) && byte_done && !start_det && !stop_det;
  assign commit_go = busy && (cidx < buf_count);
  assign prog_go   = stop_det && (st == ST_WDATA) && (buf_count != '0) && !busy;
  assign low_off   = base[PW-1:0] + cidx[PW-1:0];
  assign mem_waddr = {base[AW-1:PW], low_off};

  seeprom_wbuf #(.DEPTH(PAGE_BYTES), .DW(BYTE_W)) u_wbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .push(buf_push), .din(shreg),
    .rd_off(cidx[PW-1:0]), .dout(buf_dout), .count(buf_count)
  );

  seeprom_array #(.WORDS(MEM_BYTES), .DW(BYTE_W)) u_array (
    .clk(clk), .we(commit_go), .waddr(mem_waddr), .wdata(buf_dout),
    .raddr(ptr), .rdata(mem_rdata)
  );

  // programming interval and commit sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
      cidx  <= '0;
    end else if (prog_go) begin
      timer <= TW'(PROG_CYCLES);
      cidx  <= '0;
    end else begin
      if (busy) timer <= timer - 1'b1;
      if (commit_go) cidx <= cidx + 1'b1;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ack_ph   <= 1'b0;
      got_ack  <= 1'b0;
      rd_req   <= 1'b0;
      shreg    <= '0;
      txq      <= '0;
      ptr      <= '0;
      base     <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= ST_CTRL;
      cnt      <= '0;
      ack_ph   <= 1'b0;
      got_ack  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      ack_ph   <= 1'b0;
      got_ack  <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      unique case (st)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && !ack_ph && cnt != 4'd8) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            ack_ph <= 1'b1;
            if (st == ST_CTRL) begin
              if (shreg[7:4] == DEV_CODE && !busy) begin
                sda_pull <= 1'b1;
                rd_req   <= shreg[0];
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              sda_pull <= 1'b1;
              if (st == ST_ADDR) begin
                base <= shreg[AW-1:0];
                ptr  <= shreg[AW-1:0];
              end
            end
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            cnt    <= '0;
            if (st == ST_CTRL && rd_req) begin
              st       <= ST_RDATA;
              txq      <= mem_rdata;
              sda_pull <= ~mem_rdata[BYTE_W-1];
            end else begin
              sda_pull <= 1'b0;
              if (st == ST_CTRL) st <= ST_ADDR;
              else if (st == ST_ADDR) st <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (cnt != 4'd8) cnt <= cnt + 1'b1;
            else if (!sda_s) got_ack <= 1'b1;
            else st <= ST_SKIP;
          end else if (scl_fall) begin
            if (got_ack) begin
              got_ack  <= 1'b0;
              cnt      <= '0;
              txq      <= mem_rdata;
              sda_pull <= ~mem_rdata[BYTE_W-1];
            end else if (cnt == 4'd8) begin
              sda_pull <= 1'b0;
              ptr      <= ptr + 1'b1;
            end else begin
              txq      <= {txq[BYTE_W-2:0], 1'b0};
              sda_pull <= ~txq[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull) else $error("target drives during programming"); // R6
  AST_PROG_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det)) else $error("programming began without stop"); // R7
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_pull) else $error("line held while ignoring"); // R9
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_s) else $error("data changed with clock high"); // R12
endmodule

// File: tb/sim_seeprom_target.sv
module sim_seeprom_target;
  localparam int PROG = 400;
  localparam int Q    = 8;
  localparam int NV   = 6;
  localparam logic [15:0] VEC [NV] = '{16'h053C, 16'h7F5A, 16'h00C3,
                                       16'h40FF, 16'h4100, 16'h6699};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_scl = 1'b1;
  logic ctl_sda = 1'b1;
  logic sda_pull;
  wire  bus_sda = ctl_sda & ~sda_pull;

  always #10 clk = ~clk;

  seeprom_target #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .scl_i(ctl_scl), .sda_i(bus_sda), .sda_pull(sda_pull)
  );

  int n_chk = 0;
  int n_bad = 0;
  int viol  = 0;
  logic prev_pull = 1'b0;
  logic [7:0] rb [18];

  always @(negedge clk) begin
    if (!rst && sda_pull !== prev_pull && ctl_scl) viol++;
    prev_pull <= sda_pull;
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic v, output logic seen);
    qwait(Q); ctl_sda = v;
    qwait(Q); ctl_scl = 1'b1;
    qwait(Q); seen = bus_sda;
    qwait(Q); ctl_scl = 1'b0;
  endtask

  task automatic bstart();
    qwait(Q); ctl_sda = 1'b1;
    qwait(Q); ctl_scl = 1'b1;
    qwait(Q); ctl_sda = 1'b0;
    qwait(Q); ctl_scl = 1'b0;
  endtask

  task automatic bstop();
    qwait(Q); ctl_sda = 1'b0;
    qwait(Q); ctl_scl = 1'b1;
    qwait(Q); ctl_sda = 1'b1;
    qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output int ackd);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ackd = (s == 1'b0) ? 1 : 0;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(ack_it ? 1'b0 : 1'b1, s);
  endtask

  task automatic write_seq(input logic [7:0] addr, input int n, input logic [7:0] d0,
                           input string tag);
    int a;
    bstart();
    send_byte(8'hA0, a); chk(a, 1, tag);
    send_byte(addr, a);  chk(a, 1, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), a); chk(a, 1, tag);
    end
    bstop();
  endtask

  task automatic read_at(input logic [7:0] addr, input int n, input string tag);
    int a;
    bstart();
    send_byte(8'hA0, a); chk(a, 1, tag);
    send_byte(addr, a);  chk(a, 1, tag);
    bstart();
    send_byte(8'hA1, a); chk(a, 1, tag);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int a;
    logic s;
    qwait(3);
    chk(sda_pull, 0, "R1 during reset");
    qwait(3);
    rst = 1'b0;
    qwait(4);
    chk(sda_pull, 0, "R1 after reset");

    // table walk: single-byte write then readback
    for (int v = 0; v < NV; v++) begin
      write_seq(VEC[v][15:8], 1, VEC[v][7:0], "R3");
      qwait(PROG + 20);
      read_at(VEC[v][15:8], 1, "R3");
      chk(rb[0], VEC[v][7:0], "R3 readback");
    end

    // R2: foreign device code, following bytes ignored
    bstart();
    send_byte(8'hB0, a); chk(a, 0, "R2 foreign code");
    send_byte(8'hA0, a); chk(a, 0, "R2 ignored byte");
    bstop();

    // R4: 18 bytes, last 16 kept from the word address
    write_seq(8'h20, 18, 8'h40, "R4");
    qwait(PROG + 20);
    read_at(8'h20, 16, "R4");
    for (int i = 0; i < 16; i++) chk(rb[i], 8'h42 + i, "R4 kept bytes");

    // R5: page wrap
    write_seq(8'h1E, 4, 8'hA0, "R5");
    qwait(PROG + 20);
    read_at(8'h1E, 2, "R5");
    chk(rb[0], 8'hA0, "R5 first"); chk(rb[1], 8'hA1, "R5 second");
    read_at(8'h10, 2, "R5");
    chk(rb[0], 8'hA2, "R5 wrapped"); chk(rb[1], 8'hA3, "R5 wrapped");
    read_at(8'h20, 1, "R5");
    chk(rb[0], 8'h42, "R5 next page untouched");

    // R6 / R7: silent while programming, acknowledges afterwards
    write_seq(8'h50, 1, 8'h77, "R7");
    bstart();
    send_byte(8'hA0, a); chk(a, 0, "R6 control during programming");
    bstop();
    qwait(PROG);
    bstart();
    send_byte(8'hA0, a); chk(a, 1, "R7 control after programming");
    bstop();
    read_at(8'h50, 1, "R7");
    chk(rb[0], 8'h77, "R7 committed");

    // R8: read wraps from 0x7F to 0x00
    read_at(8'h7F, 2, "R8");
    chk(rb[0], 8'h5A, "R8 last address"); chk(rb[1], 8'hC3, "R8 wrapped");

    // R10: address-only write sets pointer, no programming
    bstart();
    send_byte(8'hA0, a); send_byte(8'h66, a); chk(a, 1, "R10 address");
    bstop();
    bstart();
    send_byte(8'hA0, a); chk(a, 1, "R10 no busy");
    bstop();
    bstart();
    send_byte(8'hA1, a); chk(a, 1, "R10 read control");
    recv_byte(1'b0, rb[0]);
    bstop();
    chk(rb[0], 8'h99, "R10 pointer");

    // R11: address bit 7 ignored
    read_at(8'h85, 1, "R11");
    chk(rb[0], 8'h3C, "R11 alias");

    // R9: released after controller withholds acknowledge
    bstart();
    send_byte(8'hA0, a); send_byte(8'h40, a);
    bstart();
    send_byte(8'hA1, a); chk(a, 1, "R9 control");
    recv_byte(1'b0, rb[0]);
    chk(rb[0], 8'hFF, "R9 data");
    clk_bit(1'b1, s); chk(s, 1, "R9 extra pulse one");
    clk_bit(1'b1, s); chk(s, 1, "R9 extra pulse two");
    bstop();

    chk(viol, 0, "R12 data changes only with clock low");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule